// File: doc/BRIEF.md
# Long-Register Normalize Shifter

This block normalizes a fixed-point value held in a pair of 18-bit registers, an accumulator and a multiplier-quotient word. The pair is joined into one 36-bit long register with the accumulator as the upper half. The block shifts the long register left one position per clock until the two most significant accumulator bits hold different values, or until a 6-bit step counter runs out. Each vacated bit at the bottom of the long register is filled from a link bit.

The step counter is loaded with the two's complement of a requested step limit. A limit of 36 covers the full register. The counter advances once per shift. At the end it therefore holds the negated limit plus the number of shifts made, which the caller uses as a biased scale factor. In the signed form, the link is first loaded with the accumulator's sign bit, so the sign fills the value from below. In the unsigned form, the caller supplies the link.

A request enters through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a normalization is running, `req_ready` stays low and any offered request is held off, without effect, until the block is idle again. Results remain on the outputs until the next request is taken. `done` is a plain one-cycle status pulse.

Top module: `lrn_normalizer`

## Requirements
- R1: `req_ready` is high exactly when no normalization is in progress. A request is accepted only on an edge with `req_valid` and `req_ready` both high. Request inputs offered while `req_ready` is low change no output.
- R2: On acceptance, the link takes `req_link` when `req_signed` is 0, and takes `req_acc[17]` (the accumulator's most significant bit) when `req_signed` is 1. The link then stays constant throughout the normalization.
- R3: On acceptance, `acc` and `mq` take `req_acc` and `req_mq`, and `sc` takes (64 - `req_count`) mod 64.
- R4: Each shift step replaces `acc` with {acc[16:0], mq[17]} and `mq` with {mq[16:0], link}. The old `acc[17]` is discarded.
- R5: Each shift step increments `sc` by one, modulo 64.
- R6: Shifting stops without a further shift once `acc[17]` differs from `acc[16]`.
- R7: Shifting stops once `sc` is zero. A `req_count` of 0 therefore gives no shift.
- R8: If the stop condition already holds on the accepted value, no shift occurs. `done` rises one edge later, with `acc`, `mq` and `sc` still at their loaded values.
- R9: For a normalization of n shifts, `done` is high for exactly one cycle, starting n+1 edges after the accepting edge. While idle with no accepted request, `acc`, `mq`, `link` and `sc` hold their values.
- R10: The final `sc` equals (64 - `req_count` + n) mod 64, where n is the number of shifts made.
- R11: While `rst_n` is low, `acc`, `mq`, `link`, `sc` and `done` are zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request can be taken |
| req_signed | input | 1 | 1 selects signed normalize (link loaded from accumulator sign) |
| req_count | input | 6 | Step limit; counter starts at its two's complement |
| req_acc | input | 18 | Accumulator operand, bit 17 most significant |
| req_mq | input | 18 | Lower half of the long register |
| req_link | input | 1 | Fill bit for the unsigned form |
| acc | output | 18 | Accumulator, upper half of the long register |
| mq | output | 18 | Lower half of the long register |
| link | output | 1 | Fill bit in use |
| sc | output | 6 | Step counter |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
The bench targets these cases:
- **Step limit of zero.** A design that treated the limit of zero as 64 would shift the whole register away.
- **Already-normalized operand.** A design that shifted once before testing the stop condition would leave a shifted `acc`.
- **All-zero and all-ones long registers under both link values and both forms.** These separate the counter-limited stop from the bit-difference stop. A 35-shift result with a counter of 63 shows that the fill bit really enters at the bottom of `mq`.
- **New requests offered while busy.** A design that did not hold them off would reload the operands mid-run. This shows up at once in the cycle-by-cycle comparison and in the one-pulse `done` latency.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

  // Control phases of the normalizer.
  typedef enum logic {
    LRN_IDLE = 1'b0,
    LRN_RUN  = 1'b1
  } lrn_state_e;

  // Default geometry of the long register and step counter.
  localparam int unsigned LRN_WORD_W_DEF = 18;
  localparam int unsigned LRN_SC_W_DEF   = 6;

endpackage

// File: rtl/lrn_ctrl.sv
module lrn_ctrl
  import lrn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic stop,
  output logic req_ready,
  output logic load,
  output logic shift_en,
  output logic done
);

  lrn_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    shift_en = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      LRN_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          state_d = LRN_RUN;
        end
      end
      LRN_RUN: begin
        if (stop) begin
          done_d  = 1'b1;
          state_d = LRN_IDLE;
        end else begin
          shift_en = 1'b1;
        end
      end
      default: state_d = LRN_IDLE;
    endcase
  end

  assign req_ready = (state_q == LRN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LRN_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/lrn_stepcnt.sv
module lrn_stepcnt #(
  parameter int unsigned SC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SC_W-1:0] limit,
  input  logic            inc,
  output logic [SC_W-1:0] sc,
  output logic            sc_zero
);

  localparam logic [SC_W-1:0] ONE = SC_W'(1);

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (load) begin
      sc_q <= (~limit) + ONE;
    end else if (inc) begin
      sc_q <= sc_q + ONE;
    end
  end

  assign sc      = sc_q;
  assign sc_zero = (sc_q == '0);

endmodule

// File: rtl/lrn_datapath.sv
module lrn_datapath #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic              is_signed,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] mq_in,
  input  logic              link_in,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] mq,
  output logic              link,
  output logic              top_differ
);

  localparam int unsigned LONG_W = 2 * WORD_W;

  logic [LONG_W-1:0] long_q, long_d, load_word;
  logic              link_q;

  assign load_word = {acc_in, mq_in};

  // Per-bit next value: load, shift up by one, or hold.
  generate
    for (genvar b = 0; b < LONG_W; b++) begin : g_bit
      if (b == 0) begin : g_fill
        assign long_d[b] = load     ? load_word[b] :
                           shift_en ? link_q       : long_q[b];
      end else begin : g_chain
        assign long_d[b] = load     ? load_word[b]  :
                           shift_en ? long_q[b-1]   : long_q[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q <= '0;
      link_q <= 1'b0;
    end else begin
      long_q <= long_d;
      if (load) begin
        link_q <= is_signed ? acc_in[WORD_W-1] : link_in;
      end
    end
  end

  assign acc        = long_q[LONG_W-1:WORD_W];
  assign mq         = long_q[WORD_W-1:0];
  assign link       = link_q;
  assign top_differ = long_q[LONG_W-1] ^ long_q[LONG_W-2];

endmodule

// File: rtl/lrn_normalizer.sv
module lrn_normalizer #(
  parameter int unsigned WORD_W = lrn_pkg::LRN_WORD_W_DEF,
  parameter int unsigned SC_W   = lrn_pkg::LRN_SC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_signed,
  input  logic [SC_W-1:0]   req_count,
  input  logic [WORD_W-1:0] req_acc,
  input  logic [WORD_W-1:0] req_mq,
  input  logic              req_link,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] mq,
  output logic              link,
  output logic [SC_W-1:0]   sc,
  output logic              done
);

  logic load, shift_en, stop, top_differ, sc_zero;

  assign stop = top_differ | sc_zero;

  lrn_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .stop      (stop),
    .req_ready (req_ready),
    .load      (load),
    .shift_en  (shift_en),
    .done      (done)
  );

  lrn_stepcnt #(.SC_W(SC_W)) u_stepcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .limit   (req_count),
    .inc     (shift_en),
    .sc      (sc),
    .sc_zero (sc_zero)
  );

  lrn_datapath #(.WORD_W(WORD_W)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .shift_en   (shift_en),
    .is_signed  (req_signed),
    .acc_in     (req_acc),
    .mq_in      (req_mq),
    .link_in    (req_link),
    .acc        (acc),
    .mq         (mq),
    .link       (link),
    .top_differ (top_differ)
  );

endmodule

// File: rtl/lrn_chk.sv
module lrn_chk #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned SC_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_signed,
  input logic [SC_W-1:0]   req_count,
  input logic [WORD_W-1:0] req_acc,
  input logic [WORD_W-1:0] req_mq,
  input logic              req_link,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] mq,
  input logic              link,
  input logic [SC_W-1:0]   sc,
  input logic              done
);

  logic accept, running_step;
  assign accept       = req_valid && req_ready;
  assign running_step = !req_ready && (acc[WORD_W-1] == acc[WORD_W-2]) && (sc != '0);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R2
  link_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_signed) |=> (link == $past(req_link)));

  // R2
  link_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_signed) |=> (link == $past(req_acc[WORD_W-1])));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (acc == $past(req_acc)) && (mq == $past(req_mq))
               && (sc == SC_W'(0 - $past(req_count))));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_step |=> (acc == {$past(acc[WORD_W-2:0]), $past(mq[WORD_W-1])})
                     && (mq == {$past(mq[WORD_W-2:0]), $past(link)}));

  // R5
  sc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_step |=> (sc == $past(sc) + SC_W'(1)) && $stable(link));

  // R6
  differ_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (acc[WORD_W-1] != acc[WORD_W-2])) |=> done && $stable(acc) && $stable(mq));

  // R7
  sc_zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (sc == '0)) |=> done && $stable(sc));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(acc) && $stable(mq) && $stable(link) && $stable(sc));

endmodule

bind lrn_normalizer lrn_chk #(.WORD_W(WORD_W), .SC_W(SC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_signed (req_signed),
  .req_count  (req_count),
  .req_acc    (req_acc),
  .req_mq     (req_mq),
  .req_link   (req_link),
  .acc        (acc),
  .mq         (mq),
  .link       (link),
  .sc         (sc),
  .done       (done)
);

// File: tb/lrn_normalizer_tb_top.sv
module lrn_normalizer_tb_top;

  localparam int WW = 18;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_signed = 1'b0;
  logic [SW-1:0] req_count = '0;
  logic [WW-1:0] req_acc = '0;
  logic [WW-1:0] req_mq = '0;
  logic          req_link = 1'b0;
  logic [WW-1:0] acc, mq;
  logic          link;
  logic [SW-1:0] sc;
  logic          done;

  always #4 clk = ~clk;

  lrn_normalizer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_signed(req_signed), .req_count(req_count), .req_acc(req_acc),
    .req_mq(req_mq), .req_link(req_link), .acc(acc), .mq(mq), .link(link),
    .sc(sc), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural cycle model.
  bit          m_busy = 0;
  logic [35:0] m_word = '0;
  bit          m_link = 0;
  int          m_sc = 0;
  bit          m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_word = '0; m_link = 0; m_sc = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_word = {req_acc, req_mq};
          m_link = req_signed ? req_acc[WW-1] : req_link;
          m_sc   = (64 - int'(req_count)) % 64;
          m_busy = 1;
        end
      end else if (m_word[35] != m_word[34] || m_sc == 0) begin
        m_busy = 0;
        m_done = 1;
      end else begin
        m_word = {m_word[34:0], m_link};
        m_sc   = (m_sc + 1) % 64;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4", "acc", 64'(acc), 64'(m_word[35:18]));
      chk("R4", "mq", 64'(mq), 64'(m_word[17:0]));
      chk("R2", "link", 64'(link), 64'(m_link));
      chk("R5", "sc", 64'(sc), 64'(m_sc));
      chk("R6", "done", 64'(done), 64'(m_done));
      chk("R1", "req_ready", 64'(req_ready), 64'(!m_busy));
    end
  end

  task automatic run_op(input logic [WW-1:0] a, input logic [WW-1:0] q,
                        input bit lk, input bit sg, input int cnt, input bit noisy);
    logic [35:0] w;
    bit          fill;
    int          s, n, edges;
    w = {a, q};
    fill = sg ? a[WW-1] : lk;
    s = (64 - cnt) % 64;
    n = 0;
    while (s != 0 && w[35] == w[34]) begin
      w = {w[34:0], fill};
      s = (s + 1) % 64;
      n++;
    end
    @(negedge clk);
    req_valid = 1'b1; req_acc = a; req_mq = q; req_link = lk;
    req_signed = sg; req_count = SW'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    edges = 0;
    // R3: loaded counter visible right after the accepting edge
    chk("R3", "sc after load", 64'(sc), 64'((64 - cnt) % 64));
    while (!done) begin
      if (noisy) begin
        req_valid = 1'b1; req_acc = WW'($urandom); req_mq = WW'($urandom);
        req_count = SW'($urandom); req_signed = 1'($urandom); req_link = 1'($urandom);
      end
      @(negedge clk);
      edges++;
    end
    req_valid = 1'b0;
    chk("R9", "done latency", 64'(edges), 64'(n + 1));
    chk("R10", "final sc", 64'(sc), 64'(s));
    chk("R10", "final long reg", 64'({acc, mq}), 64'(w));
    if (cnt == 0) chk("R7", "no shift on zero limit", 64'({acc, mq}), 64'({a, q}));
    else if (n == 0) chk("R8", "already normalized unchanged", 64'({acc, mq}), 64'({a, q}));
    if (s != 0) chk("R6", "stopped on differing top bits", 64'(acc[WW-1] ^ acc[WW-2]), 64'(1));
    else chk("R7", "stopped with counter at zero", 64'(sc), 64'(0));
    if (noisy) chk("R1", "busy offers ignored", 64'({acc, mq}), 64'(w));
    @(negedge clk);
    chk("R9", "done one cycle", 64'(done), 64'(0));
    chk("R9", "idle hold", 64'({acc, mq}), 64'(w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk("R11", "reset acc/mq", 64'({acc, mq}), 64'(0));
    chk("R11", "reset sc/link/done", 64'({sc, link, done}), 64'(0));
    chk("R11", "reset ready", 64'(req_ready), 64'(1));
    rst_n = 1'b1;
    @(negedge clk);
    run_op(18'h00123, 18'h2AAAA, 1'b0, 1'b0, 0, 1'b0);   // R7 zero limit
    run_op(18'h20000, 18'h00001, 1'b0, 1'b0, 36, 1'b0);  // R8 already normalized
    run_op(18'h00000, 18'h00000, 1'b0, 1'b0, 36, 1'b0);  // R7 all zero, 36 shifts
    run_op(18'h00000, 18'h00000, 1'b1, 1'b0, 36, 1'b0);  // 35 shifts, sc 63
    run_op(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b1, 36, 1'b0);  // signed all ones
    run_op(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 36, 1'b0);  // unsigned all ones
    run_op(18'h3FFF0, 18'h01234, 1'b0, 1'b1, 36, 1'b0);  // R2 signed negative
    run_op(18'h00007, 18'h15555, 1'b1, 1'b0, 5, 1'b1);   // R1 limit backstop, noisy
    run_op(18'h00001, 18'h00000, 1'b0, 1'b0, 63, 1'b1);  // R1 noisy long run
    for (int i = 0; i < 60; i++) begin
      run_op(WW'($urandom) >> ($urandom % 18), WW'($urandom), 1'($urandom), 1'($urandom),
             (i % 3 == 0) ? 36 : int'($urandom % 64), 1'(i % 4 == 1));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule